// File: doc/BRIEF.md
# Character Display Memory Write Controller

This block takes 6-bit character codes from a processor bus and places them in a small display memory of eight 6-bit entries. Entry 0 holds the left-most character on the display. A separate combinational read port, with its own address, lets scan logic fetch any entry at any time. A write takes effect only while the write strobe is low and both chip selects are active. Control values are captured when that qualified strobe starts. Data is captured when the strobe ends.

The access mode is captured at the start of each qualified strobe. In random mode the write location is the 3-bit address captured at the strobe start. In sequential mode an internal location counter supplies the write location, and the address pins change roles:

- Bit 0 becomes a cascade enable.
- Bit 1 becomes an active-low clear.
- Bit 2 becomes a display-full output. It has its own drive-enable, so that bit can be brought out on a shared pin.

A controller that is full or not enabled ignores the write. Several controllers can therefore be chained, each one's full flag enabling the next. All pins are passed through a synchroniser on the system clock, and strobe edges are found on the synchronised signal.

Top module: `dispwr_ctrl`

## Requirements
- R1: After a synchronous reset the following hold:
  - every entry reads 6'b100000 (the blank code);
  - the location counter is 0;
  - the access mode is random;
  - `full_oe` and `full_out` are low.
- R2: A write happens only while `wr_n`=0, `cs`=1 and `cs_n`=0. A strobe with either chip select inactive changes no entry, no counter and no mode.
- R3: In random mode (`mode`=0 at strobe start) the entry written is `addr_in` as it was at strobe start. An address change during the strobe has no effect on that write.
- R4: The value stored is `data_in` as it is when the qualified strobe ends.
- R5: The access mode is taken from `mode` at strobe start (1 = sequential, 0 = random). A change on `mode` during the strobe does not alter that write.
- R6: In sequential mode the enable is `addr_in[0]`, taken at strobe start. When the enable is 1 and the controller is not full, the data goes to the entry named by the counter, and the counter then advances by one. When the enable is 0, nothing changes.
- R7: After 8 stored sequential entries the controller is full. Further sequential writes are ignored, and `full_out` is 1 while the flag is driven.
- R8: While the captured mode is sequential, `addr_in[1]`=0 clears the controller at any time, with no strobe needed: the counter returns to 0 and every entry becomes 6'b100000. While the captured mode is random, `addr_in[1]`=0 clears nothing.
- R9: `full_oe` rises at the end of a qualified strobe that captured sequential mode. It falls at the start of a qualified strobe that captures random mode. `full_out` is 0 whenever `full_oe` is 0.
- R10: `sleep`=1 forces `full_oe` and `full_out` low. The stored entries and the counter are kept.
- R11: `rd_data` always shows the entry selected by `rd_addr`, with no clock delay.
- R12: A change on any input pin reaches internal state within SYNC_STAGES+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Write strobe, active low |
| cs | input | 1 | Chip select, active high |
| cs_n | input | 1 | Chip select, active low |
| mode | input | 1 | Access mode: 1 = sequential, 0 = random |
| addr_in | input | 3 | Random-mode address. In sequential mode bit 0 is the enable and bit 1 is the active-low clear |
| data_in | input | 6 | Character code |
| sleep | input | 1 | Shutdown: silences the full flag and keeps the contents |
| full_out | output | 1 | Display-full flag, for the shared address bit 2 pin |
| full_oe | output | 1 | Drive enable for `full_out` |
| rd_addr | input | 3 | Scan read address |
| rd_data | output | 6 | Entry at `rd_addr` |

## Verification
The checker watches the location counter on every cycle:

- it only steps by one or returns to zero;
- it never passes the depth;
- it stays at full unless a clear is active;
- it is zero one cycle after any clear.

It also checks that the full flag is never high without its drive enable.

Only the bench scenarios show the edge-specific captures:

- the address and mode taken at strobe start and the data taken at strobe end;
- the ignored writes (unqualified, not enabled, or full);
- the point where the drive enable changes around a strobe;
- that shutdown keeps the contents;
- that a clear is ignored in random mode.

// File: rtl/dw_pkg.sv
// Shared types for the display memory write controller.
// Assumes nothing beyond a single clock domain.
package dw_pkg;

    // Access mode captured at the start of each qualified strobe.
    typedef enum logic {
        ACC_RAND = 1'b0,
        ACC_SEQ  = 1'b1
    } acc_mode_e;

    // Role of the address pins while the captured mode is sequential.
    localparam int EN_BIT  = 0;
    localparam int CLR_BIT = 1;

endpackage

// File: rtl/dw_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes the bundle members are sampled together; skew between members
// is absorbed by the controller holding values across several cycles.
module dw_sync #(
    parameter int              W       = 8,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) st[g] <= RST_VAL;
                    else        st[g] <= d;
                end
            end else begin : g_next
                // Later stages settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) st[g] <= RST_VAL;
                    else        st[g] <= st[g-1];
                end
            end
        end
    endgenerate

    assign q = st[STAGES-1];

endmodule

// File: rtl/dw_strobe.sv
// Qualifies the write strobe with both chip selects and finds its edges.
// Assumes synchronised inputs. "start" marks the last enabling edge of
// any input, "stop" the first disabling edge.
module dw_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n_s,
    input  logic cs_s,
    input  logic cs_n_s,
    output logic start,
    output logic stop
);

    logic act;
    logic act_d;

    assign act = !wr_n_s && cs_s && !cs_n_s;

    // Remember the previous qualified level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_d <= 1'b0;
        else        act_d <= act;
    end

    assign start = act && !act_d;
    assign stop  = !act && act_d;

endmodule

// File: rtl/dw_seq_ctr.sv
// Sequential location counter with saturating full flag.
// Assumes "inc" is only raised for an accepted sequential write;
// the clear input wins over an increment.
module dw_seq_ctr #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          full
);

    localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

    assign full = (cnt == LIMIT);

    // Count accepted entries up to the depth, zero on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       cnt <= '0;
        else if (inc && !full)   cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/dw_mem.sv
// Display memory: one write port, combinational read port, bulk clear.
// Assumes DEPTH is a power of two so the read address covers it exactly.
module dw_mem #(
    parameter int            DEPTH = 8,
    parameter int            DW    = 6,
    parameter int            AW    = 3,
    parameter logic [DW-1:0] BLANK = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);

    logic [DW-1:0] mem [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_entry
            // Each entry blanks on reset or clear, else takes its write.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)                  mem[g] <= BLANK;
                else if (we && (wa == AW'(g)))      mem[g] <= wd;
            end
        end
    endgenerate

    assign rd = mem[ra];

endmodule

// File: rtl/dispwr_ctrl.sv
// Dual-mode display memory write controller (top).
// Captures mode and address/enable when the qualified strobe starts,
// data when it ends. Random mode writes the captured address; sequential
// mode writes the counter location and supports cascading. Assumes the
// processor holds pins for more than SYNC_STAGES+1 cycles per phase.
module dispwr_ctrl
    import dw_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int DW          = 6,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH),
    localparam int CW         = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic          cs,
    input  logic          cs_n,
    input  logic          mode,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic          sleep,
    output logic          full_out,
    output logic          full_oe,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam logic [DW-1:0] BLANK = {1'b1, {(DW-1){1'b0}}};
    localparam int            SW    = 5 + AW + DW;
    localparam logic [AW-1:0] ADDR_IDLE = AW'(1 << CLR_BIT);
    localparam logic [SW-1:0] SYNC_RST  = {5'b00110, ADDR_IDLE, BLANK};

    logic [SW-1:0] sync_q;
    logic          sleep_s, cs_s, cs_n_s, wr_n_s, mode_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] data_s;
    logic          start, stop;
    acc_mode_e     mode_q;
    logic [AW-1:0] addr_q;
    logic          seq_oe;
    logic          clr_act;
    logic          we_rand, we_seq, mem_we;
    logic [AW-1:0] mem_wa;
    logic [CW-1:0] cnt;
    logic          full;

    dw_sync #(
        .W      (SW),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sleep, cs, cs_n, wr_n, mode, addr_in, data_in}),
        .q    (sync_q)
    );

    assign {sleep_s, cs_s, cs_n_s, wr_n_s, mode_s, addr_s, data_s} = sync_q;

    dw_strobe u_stb (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_n_s(wr_n_s),
        .cs_s  (cs_s),
        .cs_n_s(cs_n_s),
        .start (start),
        .stop  (stop)
    );

    // Capture mode and address/enable at the start of a qualified strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= ACC_RAND;
            addr_q <= '0;
        end else if (start) begin
            mode_q <= acc_mode_e'(mode_s);
            addr_q <= addr_s;
        end
    end

    // Full-flag drive enable: off when random is captured, on after a sequential strobe ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                              seq_oe <= 1'b0;
        else if (start && (mode_s == ACC_RAND))  seq_oe <= 1'b0;
        else if (stop && (mode_q == ACC_SEQ))    seq_oe <= 1'b1;
    end

    assign clr_act = (mode_q == ACC_SEQ) && !addr_s[CLR_BIT];
    assign we_rand = stop && (mode_q == ACC_RAND);
    assign we_seq  = stop && (mode_q == ACC_SEQ) && addr_q[EN_BIT] && !full && !clr_act;
    assign mem_we  = we_rand || we_seq;
    assign mem_wa  = (mode_q == ACC_SEQ) ? cnt[AW-1:0] : addr_q;

    dw_seq_ctr #(
        .DEPTH(DEPTH),
        .CW   (CW)
    ) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_act),
        .inc  (we_seq),
        .cnt  (cnt),
        .full (full)
    );

    dw_mem #(
        .DEPTH(DEPTH),
        .DW   (DW),
        .AW   (AW),
        .BLANK(BLANK)
    ) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_act),
        .we   (mem_we),
        .wa   (mem_wa),
        .wd   (data_s),
        .ra   (rd_addr),
        .rd   (rd_data)
    );

    assign full_oe  = seq_oe && !sleep_s;
    assign full_out = full_oe && full;

endmodule

// File: rtl/dw_chk.sv
// Assertion checker for the write controller, bound into the top.
// Watches the location counter, the clear and the full-flag drive.
module dw_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt,
    input logic          clr_act,
    input logic          full_out,
    input logic          full_oe
);

    localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

    // R6: counter only steps up by one or returns to zero
    p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> (cnt == '0) || (cnt == $past(cnt) + 1'b1));

    // R7: counter never passes the depth
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

    // R7: a full controller stays full unless cleared
    p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LIMIT) && !clr_act |=> (cnt == LIMIT));

    // R8: a clear leaves the counter at zero
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (cnt == '0));

    // R9: full flag is never raised without its drive enable
    p_out_needs_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full_out |-> full_oe);

endmodule

bind dispwr_ctrl dw_chk #(
    .DEPTH(DEPTH),
    .CW   (CW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt),
    .clr_act (clr_act),
    .full_out(full_out),
    .full_oe (full_oe)
);

// File: tb/sim_dispwr_ctrl.sv
module sim_dispwr_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1, cs = 1'b0, cs_n = 1'b1, mode = 1'b0, sleep = 1'b0;
    logic [2:0] addr_in = 3'b010;
    logic [5:0] data_in = 6'h20;
    logic [2:0] rd_addr = 3'd0;
    logic       full_out, full_oe;
    logic [5:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [5:0] exp_mem [8];
    int         exp_cnt;
    bit         exp_seq;
    bit         exp_oe;

    always #10 clk = ~clk;

    dispwr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs(cs), .cs_n(cs_n),
        .mode(mode), .addr_in(addr_in), .data_in(data_in), .sleep(sleep),
        .full_out(full_out), .full_oe(full_oe),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < 8; i++) exp_mem[i] = 6'h20;
        exp_cnt = 0;
    endfunction

    // Pins changed: a sequential controller sees bit 1 low as a clear (R8).
    function automatic void pins_changed(input logic [2:0] a);
        if (exp_seq && !a[1]) model_clear();
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_addr = 3'(i);
            #1;
            chk({req, " R11 entry"}, int'(rd_data), int'(exp_mem[i]));
        end
        chk({req, " R9 oe"}, int'(full_oe), int'(exp_oe && !sleep));
        chk({req, " R7 full"}, int'(full_out), int'(exp_oe && !sleep && exp_cnt == 8));
    endtask

    // One strobe: early pins at strobe start, late pins before strobe end.
    task automatic wr(input bit m, input logic [2:0] a, input logic [5:0] d,
                      input bit ml, input logic [2:0] al, input logic [5:0] dl,
                      input bit qual);
        bit ok;
        @(negedge clk);
        mode = m; addr_in = a; data_in = d;
        cs = qual; cs_n = 1'b0;
        pins_changed(a);
        wait_n(4);
        wr_n = 1'b0;
        wait_n(4);
        if (qual) begin
            exp_seq = m;
            if (!m) exp_oe = 0;
        end
        chk("R9 oe mid-strobe", int'(full_oe), int'(exp_oe && !sleep));
        mode = ml; addr_in = al; data_in = dl;
        pins_changed(al);
        wait_n(4);
        wr_n = 1'b1;
        wait_n(5);
        if (qual) begin
            if (!m) exp_mem[a] = dl;
            else begin
                ok = a[0] && exp_cnt < 8 && (al[1] || !exp_seq);
                if (ok) begin
                    exp_mem[exp_cnt] = dl;
                    exp_cnt++;
                end
                exp_oe = 1;
            end
        end
        mode = m;
        cs = 1'b0; cs_n = 1'b1;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        addr_in = 3'b000;
        pins_changed(3'b000);
        wait_n(5);
        addr_in = 3'b010;
        wait_n(4);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1357));
        model_clear();
        exp_seq = 0; exp_oe = 0;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        check_all("R1 reset");

        // R3: random write at captured address
        wr(0, 3'd5, 6'h21, 0, 3'd5, 6'h21, 1);
        check_all("R3 basic");
        // R3: address change during strobe ignored
        wr(0, 3'd2, 6'h11, 0, 3'd7, 6'h11, 1);
        check_all("R3 late addr");
        // R4: data at strobe end wins
        wr(0, 3'd6, 6'h05, 0, 3'd6, 6'h3A, 1);
        check_all("R4 late data");
        // R2: unqualified strobes change nothing
        wr(0, 3'd1, 6'h0F, 0, 3'd1, 6'h0F, 0);
        check_all("R2 cs off");
        @(negedge clk); cs_n = 1'b1;
        wr_n = 1'b0; cs = 1'b1; addr_in = 3'd0; data_in = 6'h01; wait_n(5);
        wr_n = 1'b1; wait_n(5); cs = 1'b0;
        check_all("R2 cs_n off");
        // R5: mode change mid-strobe keeps random
        wr(0, 3'd3, 6'h33, 1, 3'd3, 6'h33, 1);
        check_all("R5 late mode");
        // R8: clear pin in random mode ignored
        pulse_clear();
        check_all("R8 random no clear");
        // R9/R6: switch to sequential, enable high
        wr(1, 3'b011, 6'h2A, 1, 3'b011, 6'h2A, 1);
        check_all("R6 seq first");
        // R6: enable low ignored
        wr(1, 3'b010, 6'h2B, 1, 3'b010, 6'h2B, 1);
        check_all("R6 enable low");
        // R6: enable captured at start
        wr(1, 3'b011, 6'h2C, 1, 3'b010, 6'h2C, 1);
        check_all("R6 enable captured");
        // R5: mode drop mid-strobe keeps sequential
        wr(1, 3'b011, 6'h2D, 0, 3'b011, 6'h2D, 1);
        check_all("R5 seq held");
        // R7: fill and overflow
        for (int i = 0; i < 6; i++) wr(1, 3'b111, 6'(i + 1), 1, 3'b111, 6'(i + 1), 1);
        check_all("R7 full");
        wr(1, 3'b011, 6'h3F, 1, 3'b011, 6'h3F, 1);
        check_all("R7 ignored when full");
        // R10: sleep silences flag, keeps contents
        @(negedge clk); sleep = 1'b1; wait_n(5);
        check_all("R10 sleep");
        @(negedge clk); sleep = 1'b0; wait_n(5);
        check_all("R10 wake");
        // R8: clear in sequential mode
        pulse_clear();
        check_all("R8 seq clear");
        // R9: back to random drops drive
        wr(0, 3'd4, 6'h14, 0, 3'd4, 6'h14, 1);
        check_all("R9 back to random");

        // Constrained random mix
        for (int n = 0; n < 150; n++) begin
            int kind = int'($urandom_range(0, 9));
            logic [2:0] a = 3'($urandom);
            logic [5:0] d = 6'($urandom);
            logic [5:0] dl = 6'($urandom);
            if (kind < 4)      wr(0, a, d, 0, 3'($urandom), dl, 1);
            else if (kind < 8) wr(1, {a[2], 1'b1, a[0]}, d, 1, {a[2], 1'b1, a[0]}, dl, 1);
            else if (kind < 9) pulse_clear();
            else               wr(exp_seq, {a[2], 1'b1, a[0]}, d, exp_seq, {a[2], 1'b1, a[0]}, dl, 0);
            @(negedge clk); addr_in = 3'b010;
            wait_n(4);
            check_all("R12 random mix");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule